// File: doc/BRIEF.md
# MDIO Management Master

This block drives the two-wire Ethernet PHY management bus. Software programs a timing register and then writes a 32-bit management frame. When the timing register allows it, that single write launches a serial transfer on the management clock and data pins. The frame is shifted out most significant bit first, optionally behind a run of 32 ones.

Both the classic and the extended frame flavours pass through unchanged: the block sends whatever start code and opcode software places in the upper bits. For read opcodes the block releases the data pin at the turnaround. It collects the 16 bits the PHY returns and folds them into the low half of the frame register.

A sticky completion flag reports the end of every transfer and is cleared by writing one to it. The flag is also set by one particular timing-register write. That rule lets software that programs the clock last see a transfer that was already queued as finished.

Top module: `mdio_master`

## Requirements
- R1: Register access uses `reg_addr_i`: 0 selects the frame register (32 bits, read/write), 1 selects the timing register (bits 10:0 read/write, bits 31:11 read as zero), and 2 selects the event register (bit 0 is the flag). `reg_rdata_o` shows the selected register in the same cycle. After reset all registers read zero.
- R2: A frame write starts a transfer only when timing bits 7:0 are nonzero and no transfer is running. `busy_o` is high from the cycle after such a write.
- R3: A frame write made while `busy_o` is high is discarded: the frame register keeps its value and no second transfer follows.
- R4: The timing field at bits 6:1 (DIV) sets the management clock period to 2*(DIV+1) reference cycles. The clock starts low when a transfer starts.
- R5: Each rising clock edge of a transfer carries one bit. The bits are 32 ones, then frame bits 31 down to 0. Setting timing bit 7 drops the 32 ones.
- R6: The timing field at bits 10:8 (HOLD) delays each data change to HOLD+1 reference cycles after the falling clock edge. This holds for HOLD < DIV.
- R7: A frame with bit 29 set (opcodes 10 and 11) is a read. The output enable is low for frame bit positions 16 down to 0. The 16 bits sampled on the rising edges of positions 15..0 replace frame bits 15:0 at completion, and bits 31:16 are kept.
- R8: A frame with bit 29 clear (opcodes 00 and 01) keeps the output enable high for every bit of the transfer.
- R9: A transfer ends on the falling clock edge after its last bit. In that cycle `busy_o` and the output enable drop and the completion flag is set.
- R10: The completion flag stays set until software writes a 1 to event bit 0. A write of 0 to that bit leaves it unchanged.
- R11: A timing write sets the completion flag only when three things hold together: the frame register is nonzero, the old timing bits 7:0 are zero, and the new bits 7:0 are nonzero.
- R12: While no transfer is running, `mdc_o` is low and `mdio_oe_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Selected register contents |
| busy_o | output | 1 | Transfer in progress |
| event_o | output | 1 | Sticky completion flag |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe_o | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The hardest situation to reach is the turnaround hand-over of a read. The master must release the pin exactly at frame position 16, and the PHY must drive 16 bits that the master samples on the right edges. A bench responder counts falling clock edges from the start of each transfer and drives the returned bits just after each falling edge. A scoreboard compares the pin and its enable on every rising edge, with and without the preamble. A second hard case is the write to the frame register during a running transfer. The bench issues it mid-stream and shows through readback that it was dropped.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int unsigned FRAME_W = 32;
  localparam int unsigned DATA_W  = 16;
  localparam int unsigned DIV_W   = 6;
  localparam int unsigned HOLD_W  = 3;
  localparam int unsigned SPD_W   = 1 + DIV_W + 1 + HOLD_W;

  localparam logic [1:0] A_FRAME = 2'd0;
  localparam logic [1:0] A_SPEED = 2'd1;
  localparam logic [1:0] A_EVENT = 2'd2;

  typedef struct packed {
    logic [HOLD_W-1:0] hold;
    logic              no_pre;
    logic [DIV_W-1:0]  div;
    logic              rsvd;
  } speed_t;
endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
  parameter int unsigned DIV_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             mdc_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             mdc_q;
  logic             wrap;

  assign wrap = (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign mdc_o  = mdc_q;
  assign rise_o = en_i & wrap & ~mdc_q;
  assign fall_o = en_i & wrap & mdc_q;

  AST_MDC_OFF_WHEN_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !mdc_o); // R12
endmodule

// File: rtl/mdio_hold_timer.sv
module mdio_hold_timer #(
  parameter int unsigned HOLD_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [HOLD_W-1:0] hold_i,
  output logic              fire_o
);
  logic              pend_q;
  logic [HOLD_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else if (load_i) begin
      pend_q <= 1'b1;
      cnt_q  <= hold_i;
    end else if (pend_q) begin
      if (cnt_q == '0) pend_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign fire_o = pend_q & (cnt_q == '0);

  AST_FIRE_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o && !load_i |=> !fire_o); // R6
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter #(
  parameter int unsigned PRE_LEN = 32,
  parameter int unsigned FRAME_W = 32,
  parameter int unsigned DATA_W  = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic               no_pre_i,
  input  logic               rise_i,
  input  logic               fall_i,
  input  logic               apply_i,
  input  logic               mdio_i,
  output logic               busy_o,
  output logic               load_o,
  output logic               done_o,
  output logic               rd_valid_o,
  output logic [DATA_W-1:0]  rd_data_o,
  output logic               mdio_o,
  output logic               mdio_oe_o
);
  localparam int unsigned CNT_W   = $clog2(PRE_LEN + FRAME_W + 1);
  localparam int unsigned TA_LAST = FRAME_W - DATA_W - 1;  // frame offset of second turnaround bit
  localparam int unsigned RD_FIRST = FRAME_W - DATA_W;

  logic               busy_q, pre_q, out_q, oe_q;
  logic [FRAME_W-1:0] frm_q;
  logic [CNT_W-1:0]   idx_q;
  logic [DATA_W-1:0]  rd_q;

  logic [CNT_W-1:0]   pre_len, last_idx, fidx;
  logic               in_frame, is_rd, last, nxt_bit, nxt_oe;
  logic [FRAME_W-1:0] frm_sh;

  assign pre_len  = pre_q ? CNT_W'(PRE_LEN) : '0;
  assign last_idx = pre_len + CNT_W'(FRAME_W - 1);
  assign last     = (idx_q == last_idx);
  assign in_frame = (idx_q >= pre_len);
  assign fidx     = idx_q - pre_len;
  assign is_rd    = frm_q[FRAME_W-3];
  assign frm_sh   = frm_q << fidx;
  assign nxt_bit  = in_frame ? frm_sh[FRAME_W-1] : 1'b1;
  assign nxt_oe   = !(is_rd && in_frame && fidx >= CNT_W'(TA_LAST));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      pre_q  <= 1'b0;
      out_q  <= 1'b0;
      oe_q   <= 1'b0;
      frm_q  <= '0;
      idx_q  <= '0;
      rd_q   <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        frm_q  <= frame_i;
        pre_q  <= !no_pre_i;
        idx_q  <= '0;
        out_q  <= no_pre_i ? frame_i[FRAME_W-1] : 1'b1;
        oe_q   <= 1'b1;
        rd_q   <= '0;
      end
    end else begin
      if (rise_i && is_rd && in_frame && fidx >= CNT_W'(RD_FIRST))
        rd_q <= {rd_q[DATA_W-2:0], mdio_i};
      if (fall_i) begin
        if (last) begin
          busy_q <= 1'b0;
          oe_q   <= 1'b0;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end else if (apply_i) begin
        out_q <= nxt_bit;
        oe_q  <= nxt_oe;
      end
    end
  end

  assign busy_o     = busy_q;
  assign load_o     = busy_q & fall_i & ~last;
  assign done_o     = busy_q & fall_i & last;
  assign rd_valid_o = done_o & is_rd;
  assign rd_data_o  = rd_q;
  assign mdio_o     = out_q;
  assign mdio_oe_o  = oe_q;

  AST_READ_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && rise_i && is_rd && in_frame && fidx >= CNT_W'(RD_FIRST) |-> !mdio_oe_o); // R7
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o && !mdio_oe_o); // R9
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int unsigned PRE_LEN = 32
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [1:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        busy_o,
  output logic        event_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  logic [FRAME_W-1:0] frame_q;
  speed_t             spd_q;
  logic               evt_q;

  logic wr_frame, wr_speed, wr_event;
  logic spd_on, start, spd_evt;
  logic busy, rise, fall, apply, load, done, rd_valid;
  logic [DATA_W-1:0] rd_data;

  assign wr_frame = reg_we_i && (reg_addr_i == A_FRAME);
  assign wr_speed = reg_we_i && (reg_addr_i == A_SPEED);
  assign wr_event = reg_we_i && (reg_addr_i == A_EVENT);
  assign spd_on   = (spd_q[7:0] != 8'd0);
  assign start    = wr_frame && !busy && spd_on;
  assign spd_evt  = wr_speed && (frame_q != '0) && !spd_on && (reg_wdata_i[7:0] != 8'd0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q <= '0;
      spd_q   <= '0;
      evt_q   <= 1'b0;
    end else begin
      if (rd_valid)
        frame_q[DATA_W-1:0] <= rd_data;
      else if (wr_frame && !busy)
        frame_q <= reg_wdata_i;
      if (wr_speed)
        spd_q <= speed_t'(reg_wdata_i[SPD_W-1:0]);
      if (done || spd_evt)
        evt_q <= 1'b1;
      else if (wr_event && reg_wdata_i[0])
        evt_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (reg_addr_i)
      A_FRAME: reg_rdata_o = frame_q;
      A_SPEED: reg_rdata_o = {{(32-SPD_W){1'b0}}, spd_q};
      A_EVENT: reg_rdata_o = {31'd0, evt_q};
      default: reg_rdata_o = '0;
    endcase
  end

  mdio_clk_gen #(.DIV_W(DIV_W)) u_clk (
    .clk_i, .rst_ni,
    .en_i  (busy),
    .div_i (spd_q.div),
    .mdc_o (mdc_o),
    .rise_o(rise),
    .fall_o(fall)
  );

  mdio_hold_timer #(.HOLD_W(HOLD_W)) u_hold (
    .clk_i, .rst_ni,
    .load_i(load),
    .hold_i(spd_q.hold),
    .fire_o(apply)
  );

  mdio_shifter #(.PRE_LEN(PRE_LEN), .FRAME_W(FRAME_W), .DATA_W(DATA_W)) u_shift (
    .clk_i, .rst_ni,
    .start_i   (start),
    .frame_i   (reg_wdata_i),
    .no_pre_i  (spd_q.no_pre),
    .rise_i    (rise),
    .fall_i    (fall),
    .apply_i   (apply),
    .mdio_i    (mdio_i),
    .busy_o    (busy),
    .load_o    (load),
    .done_o    (done),
    .rd_valid_o(rd_valid),
    .rd_data_o (rd_data),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o)
  );

  assign busy_o  = busy;
  assign event_o = evt_q;

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mdc_o && !mdio_oe_o); // R12
  AST_NO_START_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_frame && !busy_o && !spd_on |=> !busy_o); // R2
  AST_FRAME_WRITE_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && wr_frame && !rd_valid |=> $stable(frame_q)); // R3
  AST_EVENT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_o && !(wr_event && reg_wdata_i[0]) |=> event_o); // R10
  AST_HOLD_AT_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mdc_o) |-> $stable(mdio_o)); // R6
endmodule

// File: tb/mdio_master_bench.sv
module mdio_master_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        busy, evt, mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  always #4 clk = ~clk;

  mdio_master u_mdio_master (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .busy_o(busy), .event_o(evt),
    .mdc_o(mdc), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe), .mdio_i(mdio_i)
  );

  int total = 0, bad = 0;
  logic [1:0] exp_q[$];  // {drive, value}
  int cur_div = 0, cur_hold = 0;
  int falls = 0, since_fall = 0, cyc = 0, last_rise = 0;
  bit seen_fall = 0, rise_valid = 0;
  bit resp_read = 0;
  int resp_pre = 0;
  logic [15:0] resp_data = '0;
  logic prev_mdc = 0, prev_oe = 0, prev_mdio = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
  endtask

  // driver: program responder, push expected bit stream, launch the frame
  task automatic run_frame(input logic [31:0] frame, input bit pre, input logic [15:0] phy);
    resp_read = frame[29]; resp_pre = pre ? 32 : 0; resp_data = phy;
    falls = 0; seen_fall = 0; rise_valid = 0;
    if (pre) for (int i = 0; i < 32; i++) exp_q.push_back(2'b11);
    for (int p = 31; p >= 0; p--)
      exp_q.push_back({!(frame[29] && p <= 16), frame[p]});
    wr(2'd0, frame);
  endtask

  // monitor: scoreboard pop on rising MDC, PHY responder on falling MDC
  always @(negedge clk) begin
    if (rst_n) begin
      if (mdc && !prev_mdc) begin
        if (exp_q.size() == 0) check(0, "R5 unexpected bit", 32'(mdio_o), 32'hx);
        else begin
          logic [1:0] e;
          e = exp_q.pop_front();
          if (e[1]) check(mdio_oe && mdio_o == e[0], "R5/R8 driven bit", {30'd0, mdio_oe, mdio_o}, {30'd0, 1'b1, e[0]});
          else      check(!mdio_oe, "R7 released bit", 32'(mdio_oe), 32'd0);
        end
        if (rise_valid) check(cyc - last_rise == 2 * (cur_div + 1), "R4 period", 32'(cyc - last_rise), 32'(2 * (cur_div + 1)));
        last_rise = cyc; rise_valid = 1;
      end
      if (!mdc && prev_mdc) begin
        int f;
        falls++; since_fall = 0; seen_fall = 1;
        f = falls - resp_pre;
        if (resp_read && f >= 15 && f <= 31) mdio_i = (f == 15) ? 1'b0 : resp_data[31-f];
        else mdio_i = 1'b1;
      end else since_fall++;
      if (seen_fall && busy && mdio_oe && prev_oe && mdio_o != prev_mdio)
        check(since_fall == cur_hold + 1, "R6 hold", 32'(since_fall), 32'(cur_hold + 1));
      prev_mdc = mdc; prev_oe = mdio_oe; prev_mdio = mdio_o;
      cyc++;
    end
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=<150000", wd);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic finish_frame(input logic [31:0] exp_frame, input string tag);
    logic [31:0] d;
    wait_idle();
    check(!busy, "R9 busy cleared", 32'(busy), 32'd0);
    check(evt, "R9 event set", 32'(evt), 32'd1);
    check(exp_q.size() == 0, "R9 all bits sent", 32'(exp_q.size()), 32'd0);
    rd(2'd0, d);
    check(d == exp_frame, tag, d, exp_frame);
    wr(2'd2, 32'd1);
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 / R12 reset state
    rd(2'd0, d); check(d == 0, "R1 frame reset", d, 0);
    rd(2'd1, d); check(d == 0, "R1 speed reset", d, 0);
    rd(2'd2, d); check(d == 0, "R1 event reset", d, 0);
    check(!mdc && !mdio_oe && !busy, "R12 idle pins", {29'd0, mdc, mdio_oe, busy}, 0);
    // R11: frame zero -> no event
    wr(2'd1, 32'h4);
    check(!evt, "R11 frame zero no event", 32'(evt), 0);
    wr(2'd1, 32'hFFFF_F800);
    rd(2'd1, d); check(d == 0, "R1 speed upper bits", d, 0);
    // R2: speed zero -> frame stored but no start
    wr(2'd0, 32'h528E_A5C3);
    check(!busy, "R2 no start at zero speed", 32'(busy), 0);
    repeat (4) @(negedge clk);
    check(!busy && !mdc, "R12 still idle", {30'd0, busy, mdc}, 0);
    rd(2'd0, d); check(d == 32'h528E_A5C3, "R1 frame readback", d, 32'h528E_A5C3);
    // R11: qualifying speed write raises event
    wr(2'd1, 32'h104);
    check(evt, "R11 event from speed write", 32'(evt), 1);
    wr(2'd2, 32'd0);
    check(evt, "R10 zero write keeps flag", 32'(evt), 1);
    wr(2'd2, 32'd1);
    check(!evt, "R10 clear by one", 32'(evt), 0);
    wr(2'd1, 32'h106);
    check(!evt, "R11 old nonzero no event", 32'(evt), 0);
    wr(2'd1, 32'h104);
    cur_div = 2; cur_hold = 1;
    // classic write with preamble; mid-transfer frame write dropped (R3)
    run_frame(32'h528E_A5C3, 1, 16'h0);
    check(busy, "R2 started", 32'(busy), 1);
    repeat (40) @(negedge clk);
    wr(2'd0, 32'hFFFF_FFFF);
    finish_frame(32'h528E_A5C3, "R3 dropped write");
    // classic read, no preamble
    wr(2'd1, 32'h286); cur_div = 3; cur_hold = 2;
    check(!evt, "R11 no event", 32'(evt), 0);
    run_frame(32'h608A_0000, 0, 16'h3C5A);
    finish_frame(32'h608A_3C5A, "R7 read data classic");
    // extended address frame, preamble
    wr(2'd1, 32'h002); cur_div = 1; cur_hold = 0;
    run_frame(32'h0386_1234, 1, 16'h0);
    finish_frame(32'h0386_1234, "R8 address frame");
    // extended read, preamble
    run_frame(32'h3386_0000, 1, 16'hBEEF);
    finish_frame(32'h3386_BEEF, "R7 read data extended");
    check(!mdc && !mdio_oe, "R12 idle after", {30'd0, mdc, mdio_oe}, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule